// File: doc/BRIEF.md
# Audio DSP Multiply-Accumulate and Write-Back Shifter

This block is the arithmetic heart of a microprogrammed audio effects processor. On every program step it multiplies a signed 24-bit sample operand by a signed 13-bit coefficient operand. It drops the twelve fractional bits of the product and adds a third operand, the addend. The result goes into a 26-bit accumulator register. The addend can be forced to zero or negated by per-step control bits.

In the same step, a write-back shifter takes the accumulator value that the previous step left behind, not the one being formed now. It optionally doubles that value and optionally clamps it to the signed 24-bit range, then registers it as the write-back result. A 2-bit mode code picks the combination. Both the scaling and the clamping are decided from that one code, each separately.

Surrounding logic supplies the operands and the decoded control bits. It asserts the step strobe once per program step. The block holds its state on every cycle where the strobe is low.

Top module: `mac_shift_core`

## Requirements
- R1: On a clock edge with `stepValid` high, `accOut` becomes the low 26 bits of floor((X*Y)/4096) + B', where B' is the addend after R8/R9.
- R2: `xIn` is taken as a signed 24-bit value and `yIn` as a signed 13-bit value (two's complement, bit 23 and bit 12 are the signs).
- R3: On a clock edge with `stepValid` high, `shiftOut` is computed from the `accOut` value held before that edge, that is, the previous step's result, and never from the value being written in the same edge.
- R4: Mode code `shiftMode` = 0 passes the accumulator unscaled and saturates it to the range -8388608 to 8388607.
- R5: Mode code 1 doubles the accumulator (one-bit left shift) and saturates it to the same 24-bit range.
- R6: Mode code 2 doubles the accumulator with no saturation; the result wraps to 26 bits.
- R7: Mode code 3 passes the accumulator unscaled with no saturation.
- R8: With `zeroB` high the addend is zero, whatever `bIn` and `negB` hold.
- R9: With `negB` high and `zeroB` low the addend is the two's-complement negation of `bIn`, wrapped to 26 bits.
- R10: On a clock edge with `stepValid` low, `accOut` and `shiftOut` keep their values.
- R11: While `rstN` is low, `accOut` and `shiftOut` are zero.
- R12: Saturation compares the accumulator as a signed 26-bit value, so a large negative accumulator clamps to -8388608, which `shiftOut` shows as 26'h3800000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| stepValid | input | 1 | High on cycles that execute a program step |
| xIn | input | 24 | Signed multiplicand |
| yIn | input | 13 | Signed multiplier |
| bIn | input | 26 | Signed addend |
| shiftMode | input | 2 | Write-back scale/saturate mode (R4 to R7) |
| negB | input | 1 | Negate the addend |
| zeroB | input | 1 | Force the addend to zero |
| accOut | output | 26 | Accumulator |
| shiftOut | output | 26 | Registered shifted and optionally saturated previous accumulator |

## Verification
The assertions watch four properties on every cycle. Both registers hold when no step runs. Every saturating mode keeps the write-back inside the 24-bit range. Mode 3 returns exactly the previous accumulator and mode 2 returns exactly its doubled wrap. A zeroed addend times a zero multiplier leaves the accumulator at zero. The exact product arithmetic, including the sign handling of both operands, the floor rounding of the twelve-bit drop, the negated addend and the clamping of large negative values, is visible only in the bench's scenarios. There, directed extremes and seeded random steps are compared against a bench model.

// File: rtl/mac_shift_pkg.sv
package mac_shift_pkg;

  localparam int X_WIDTH    = 24;
  localparam int Y_WIDTH    = 13;
  localparam int ACC_WIDTH  = 26;
  localparam int FRAC_BITS  = 12;
  localparam int SAT_WIDTH  = 24;

  // Per-step strobes handed from control to datapath
  typedef struct packed {
    logic advance;   // execute the step
    logic scaleUp;   // double the accumulator on write-back
    logic saturate;  // clamp write-back to SAT_WIDTH signed range
    logic clearB;    // addend forced to zero
    logic negateB;   // addend negated
  } macCtrlT;

endpackage

// File: rtl/mac_shift_ctrl.sv
module mac_shift_ctrl
  import mac_shift_pkg::*;
(
  input  logic       stepValid,
  input  logic [1:0] shiftMode,
  input  logic       negB,
  input  logic       zeroB,
  output macCtrlT    ctrl
);

  always_comb begin
    ctrl.advance  = stepValid;
    // codes 1 and 2 double, codes 0 and 1 clamp
    ctrl.scaleUp  = shiftMode[0] ^ shiftMode[1];
    ctrl.saturate = ~shiftMode[1];
    ctrl.clearB   = zeroB;
    ctrl.negateB  = negB & ~zeroB;
  end

endmodule

// File: rtl/mac_shift_dp.sv
module mac_shift_dp
  import mac_shift_pkg::*;
#(
  parameter int X_W   = X_WIDTH,
  parameter int Y_W   = Y_WIDTH,
  parameter int ACC_W = ACC_WIDTH,
  parameter int FRAC  = FRAC_BITS,
  parameter int SAT_W = SAT_WIDTH
) (
  input  logic             clk,
  input  logic             rstN,
  input  macCtrlT          ctrl,
  input  logic [X_W-1:0]   xIn,
  input  logic [Y_W-1:0]   yIn,
  input  logic [ACC_W-1:0] bIn,
  output logic [ACC_W-1:0] accOut,
  output logic [ACC_W-1:0] shiftOut
);

  localparam int    PROD_W  = X_W + Y_W;
  localparam int    WIDE_W  = ACC_W + 1;
  localparam longint SAT_MAX = (longint'(1) << (SAT_W - 1)) - 1;
  localparam longint SAT_MIN = -(longint'(1) << (SAT_W - 1));

  logic [ACC_W-1:0] accReg;
  logic [ACC_W-1:0] shiftReg;

  // Multiply-add path
  logic signed [PROD_W-1:0] product;
  logic signed [PROD_W-1:0] productScaled;
  logic [ACC_W-1:0]         addend;
  logic [ACC_W-1:0]         accNext;

  always_comb begin
    product       = $signed(xIn) * $signed(yIn);
    productScaled = product >>> FRAC;
    if (ctrl.clearB)       addend = '0;
    else if (ctrl.negateB) addend = -bIn;
    else                   addend = bIn;
    accNext = productScaled[ACC_W-1:0] + addend;
  end

  // Write-back shifter on the previous accumulator
  logic signed [WIDE_W-1:0] accWide;
  logic signed [WIDE_W-1:0] accScaled;
  logic [ACC_W-1:0]         shiftNext;

  always_comb begin
    accWide   = $signed({accReg[ACC_W-1], accReg});
    accScaled = ctrl.scaleUp ? (accWide <<< 1) : accWide;
    shiftNext = accScaled[ACC_W-1:0];
    if (ctrl.saturate) begin
      if (longint'(accScaled) > SAT_MAX)      shiftNext = ACC_W'(SAT_MAX);
      else if (longint'(accScaled) < SAT_MIN) shiftNext = ACC_W'(SAT_MIN);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      accReg   <= '0;
      shiftReg <= '0;
    end else if (ctrl.advance) begin
      accReg   <= accNext;
      shiftReg <= shiftNext;
    end
  end

  assign accOut   = accReg;
  assign shiftOut = shiftReg;

endmodule

// File: rtl/mac_shift_core.sv
module mac_shift_core
  import mac_shift_pkg::*;
#(
  parameter int X_W   = X_WIDTH,
  parameter int Y_W   = Y_WIDTH,
  parameter int ACC_W = ACC_WIDTH,
  parameter int FRAC  = FRAC_BITS,
  parameter int SAT_W = SAT_WIDTH
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             stepValid,
  input  logic [X_W-1:0]   xIn,
  input  logic [Y_W-1:0]   yIn,
  input  logic [ACC_W-1:0] bIn,
  input  logic [1:0]       shiftMode,
  input  logic             negB,
  input  logic             zeroB,
  output logic [ACC_W-1:0] accOut,
  output logic [ACC_W-1:0] shiftOut
);

  macCtrlT ctrl;

  mac_shift_ctrl ctrl_i (
    .stepValid (stepValid),
    .shiftMode (shiftMode),
    .negB      (negB),
    .zeroB     (zeroB),
    .ctrl      (ctrl)
  );

  mac_shift_dp #(
    .X_W   (X_W),
    .Y_W   (Y_W),
    .ACC_W (ACC_W),
    .FRAC  (FRAC),
    .SAT_W (SAT_W)
  ) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .ctrl     (ctrl),
    .xIn      (xIn),
    .yIn      (yIn),
    .bIn      (bIn),
    .accOut   (accOut),
    .shiftOut (shiftOut)
  );

endmodule

// File: rtl/mac_shift_core_chk.sv
module mac_shift_core_chk #(
  parameter int Y_W   = 13,
  parameter int ACC_W = 26,
  parameter int SAT_W = 24
) (
  input logic             clk,
  input logic             rstN,
  input logic             stepValid,
  input logic [Y_W-1:0]   yIn,
  input logic [1:0]       shiftMode,
  input logic             zeroB,
  input logic [ACC_W-1:0] accOut,
  input logic [ACC_W-1:0] shiftOut
);

  localparam longint SAT_MAX = (longint'(1) << (SAT_W - 1)) - 1;
  localparam longint SAT_MIN = -(longint'(1) << (SAT_W - 1));

  // R10: idle cycles keep both registers
  a_r10_hold_when_idle: assert property (@(posedge clk) disable iff (!rstN)
    !stepValid |=> ($stable(accOut) && $stable(shiftOut)));

  // R4, R5, R12: saturating modes stay inside the 24-bit range
  a_r4_sat_range: assert property (@(posedge clk) disable iff (!rstN)
    (stepValid && !shiftMode[1]) |=>
      (longint'($signed(shiftOut)) <= SAT_MAX && longint'($signed(shiftOut)) >= SAT_MIN));

  // R7, R3: mode 3 returns the previous accumulator unchanged
  a_r7_pass_prev: assert property (@(posedge clk) disable iff (!rstN)
    (stepValid && shiftMode == 2'd3) |=> (shiftOut == $past(accOut)));

  // R6, R3: mode 2 returns the previous accumulator doubled, wrapped
  a_r6_double_wrap: assert property (@(posedge clk) disable iff (!rstN)
    (stepValid && shiftMode == 2'd2) |=> (shiftOut == {$past(accOut[ACC_W-2:0]), 1'b0}));

  // R8: zero multiplier with cleared addend leaves zero
  a_r8_zero_addend: assert property (@(posedge clk) disable iff (!rstN)
    (stepValid && zeroB && yIn == '0) |=> (accOut == '0));

  // R11: reset state
  always_comb begin
    if (!rstN) begin
      a_r11_reset_clear: assert (accOut == '0 && shiftOut == '0);
    end
  end

endmodule

bind mac_shift_core mac_shift_core_chk #(
  .Y_W   (Y_W),
  .ACC_W (ACC_W),
  .SAT_W (SAT_W)
) chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .stepValid (stepValid),
  .yIn       (yIn),
  .shiftMode (shiftMode),
  .zeroB     (zeroB),
  .accOut    (accOut),
  .shiftOut  (shiftOut)
);

// File: tb/mac_shift_core_tb.sv
module mac_shift_core_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        stepValid = 1'b0;
  logic [23:0] xIn = '0;
  logic [12:0] yIn = '0;
  logic [25:0] bIn = '0;
  logic [1:0]  shiftMode = '0;
  logic        negB = 1'b0;
  logic        zeroB = 1'b0;
  logic [25:0] accOut;
  logic [25:0] shiftOut;

  int checks = 0;
  int errors = 0;
  logic [25:0] modelAcc = '0;
  logic [25:0] modelShift = '0;

  always #4 clk = ~clk;

  mac_shift_core dut_i (
    .clk(clk), .rstN(rstN), .stepValid(stepValid), .xIn(xIn), .yIn(yIn),
    .bIn(bIn), .shiftMode(shiftMode), .negB(negB), .zeroB(zeroB),
    .accOut(accOut), .shiftOut(shiftOut)
  );

  function automatic logic [25:0] accModel(logic [23:0] x, logic [12:0] y,
                                           logic [25:0] b, bit neg, bit zero);
    longint px = longint'($signed(x));
    longint py = longint'($signed(y));
    longint pb = longint'($signed(b));
    longint r  = (px * py) >>> 12;
    if (zero)     pb = 0;
    else if (neg) pb = -pb;
    r = r + pb;
    return r[25:0];
  endfunction

  function automatic logic [25:0] shiftModel(logic [25:0] acc, logic [1:0] mode);
    longint a = longint'($signed(acc));
    if (mode == 2'd1 || mode == 2'd2) a = a * 2;
    if (mode < 2'd2) begin
      if (a > 64'sd8388607)  a = 64'sd8388607;
      if (a < -64'sd8388608) a = -64'sd8388608;
    end
    return a[25:0];
  endfunction

  task automatic check(string req, logic [25:0] act, logic [25:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic doStep(logic [23:0] x, logic [12:0] y, logic [25:0] b,
                        logic [1:0] mode, bit neg, bit zero, bit valid, string req);
    @(negedge clk);
    xIn = x; yIn = y; bIn = b; shiftMode = mode;
    negB = neg; zeroB = zero; stepValid = valid;
    if (valid) begin
      modelShift = shiftModel(modelAcc, mode);
      modelAcc   = accModel(x, y, b, neg, zero);
    end
    @(negedge clk);
    stepValid = 1'b0;
    check({req, " acc"},   accOut,   modelAcc);
    check({req, " shift"}, shiftOut, modelShift);
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    check("R11 reset acc", accOut, 26'h0);
    check("R11 reset shift", shiftOut, 26'h0);
    rstN = 1'b1;

    // R1 R2: basic products, signed operands
    doStep(24'h100000, 13'h0800, 26'h0000010, 2'd3, 0, 0, 1, "R1");
    doStep(24'hF00000, 13'h0800, 26'h0, 2'd3, 0, 0, 1, "R2 negX");
    doStep(24'h000003, 13'h1FFF, 26'h0, 2'd3, 0, 0, 1, "R2 floor");
    doStep(24'h7FFFFF, 13'h1000, 26'h0, 2'd0, 0, 0, 1, "R2 minY");
    // R8 R9: addend control
    doStep(24'h0, 13'h0, 26'h0001234, 2'd3, 1, 0, 1, "R9 negate");
    doStep(24'h0, 13'h0, 26'h1FFFFFF, 2'd3, 1, 1, 1, "R8 zero");
    doStep(24'h0, 13'h0, 26'h2000000, 2'd3, 1, 0, 1, "R9 minB");
    // R4: large positive clamps, mode 0
    doStep(24'h0, 13'h0, 26'h1000000, 2'd0, 0, 0, 1, "R4 load");
    doStep(24'h0, 13'h0, 26'h0000005, 2'd0, 0, 0, 1, "R4 clamp");
    // R12: large negative clamps to 3800000
    doStep(24'h0, 13'h0, 26'h2000001, 2'd0, 0, 0, 1, "R12 load");
    doStep(24'h0, 13'h0, 26'h0, 2'd0, 0, 0, 1, "R12 clamp");
    check("R12 literal", shiftOut, 26'h3800000);
    // R5: doubling saturates
    doStep(24'h0, 13'h0, 26'h0500000, 2'd1, 0, 0, 1, "R5 load");
    doStep(24'h0, 13'h0, 26'h0, 2'd1, 0, 0, 1, "R5 clamp");
    check("R5 literal", shiftOut, 26'h07FFFFF);
    // R6: doubling wraps
    doStep(24'h0, 13'h0, 26'h1800000, 2'd2, 0, 0, 1, "R6 load");
    doStep(24'h0, 13'h0, 26'h0, 2'd2, 0, 0, 1, "R6 wrap");
    check("R6 literal", shiftOut, 26'h3000000);
    // R7 R3: pass previous value unclamped
    doStep(24'h0, 13'h0, 26'h1ABCDEF, 2'd3, 0, 0, 1, "R7 load");
    doStep(24'h0, 13'h0, 26'h0000001, 2'd3, 0, 0, 1, "R3 prev");
    check("R3 literal", shiftOut, 26'h1ABCDEF);
    // R10: idle strobe changes nothing
    doStep(24'h7FFFFF, 13'h0FFF, 26'h1234567, 2'd1, 1, 0, 0, "R10 idle");

    for (int i = 0; i < 400; i++) begin
      logic [1:0] m = 2'($urandom);
      string tag;
      case (m)
        2'd0: tag = "R4 rand";
        2'd1: tag = "R5 rand";
        2'd2: tag = "R6 rand";
        default: tag = "R7 rand";
      endcase
      doStep(24'($urandom), 13'($urandom), 26'($urandom), m,
             1'($urandom), ($urandom % 8) == 0, ($urandom % 5) != 0, tag);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule